// File: doc/BRIEF.md
# Guarded Single-Precision Absolute-Value Unit

This execution unit takes one 32-bit IEEE-754 single-precision operand and returns its magnitude after a fixed pipeline of three cycles. A new operation can be issued on every clock. The unit is not a plain sign-bit clear. A subnormal operand is flushed to +0.0 and raises the input-flush flag. Every NaN comes back as the all-ones pattern. A signalling NaN also raises the invalid flag.

Each operation carries a guard bit. When the guard is false, the operation produces no write-back and changes no flag. A mode input selects one of two forms. The normal form returns the magnitude. The flags-only form returns, as the result word, the exception flags the operation would have raised, and it leaves the status register alone.

The unit also holds the sticky floating-point exception status register. Operations can only set its bits. An update vector from other floating-point units that retire in the same cycle is OR-merged into it. A software write port is the only way to clear it.

Top module: `fp_abs_unit`

## Requirements
- R1: An operation presented with issueValid high at clock edge n appears on wbValid/wbData right after edge n+2, which is a latency of 3 cycles. Operations issued on consecutive edges come out on consecutive cycles, in issue order.
- R2: For a non-NaN operand with a nonzero exponent field, wbData is the operand with bit 31 cleared. This covers normals and infinities. A zero of either sign gives 0x00000000.
- R3: A subnormal operand (exponent bits 30:23 all zero, mantissa bits 22:0 nonzero) gives 0x00000000 and raises the input-flush flag, bit 3 of the flag vector.
- R4: A quiet NaN (exponent all ones, mantissa bit 22 set) gives 0xFFFFFFFF and raises no flag.
- R5: A signalling NaN (exponent all ones, mantissa nonzero with bit 22 clear) gives 0xFFFFFFFF and raises the invalid flag, bit 4 of the flag vector.
- R6: When issueGuard is 0, wbValid stays low for that operation and flagsOut is not changed by it.
- R7: With issueFlagsOnly high and the guard true, wbData is the 5-bit flag vector {invalid, input-flush, output-flush, overflow, underflow} (bits 4 down to 0), zero-extended to 32 bits. The status register is not updated by that operation.
- R8: The status register is sticky. On the edge where a committed normal-form result is on wbValid, the operation's flags and extUpdate are ORed into the current value. The new value shows on flagsOut after that edge. This unit itself sets only bits 4 and 3.
- R9: A software write (swWrite high) loads swData ORed with any operation flags and extUpdate bits arriving on the same edge. With swWrite low, no bit of flagsOut ever goes from 1 to 0.
- R10: While rstN is low, wbValid is 0 and flagsOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is presented this cycle |
| issueGuardLsb | input | 1 | Least significant bit of the guard operand |
| issueFlagsOnly | input | 1 | 1 selects the flags-only form |
| srcOperand | input | 32 | Single-precision operand |
| extUpdate | input | 5 | Flag updates from other units retiring this cycle |
| swWrite | input | 1 | Explicit status-register write strobe |
| swData | input | 5 | Value for the explicit write |
| wbValid | output | 1 | Destination write-back strobe |
| wbData | output | 32 | Destination value |
| flagsOut | output | 5 | Sticky exception flags |

## Verification
The assertions assume three things about the inputs. First, issue controls are only meaningful while issueValid is high. Second, extUpdate carries only bits that another unit genuinely raises in that cycle. Third, swWrite is a one-cycle strobe from the register-write path. The stimulus drives every input on the falling edge and returns issueValid, swWrite and extUpdate to zero once their cycle has passed. This keeps every flag change tied to a known edge. Operand values are chosen from each class boundary: signed zeros, largest finite value, infinity, subnormal, quiet NaN and signalling NaN.

// File: rtl/fp_abs_pkg.sv
package fp_abs_pkg;
  localparam int FLAG_W  = 5;
  localparam int INV_BIT = 4;
  localparam int IFZ_BIT = 3;
  localparam int OFZ_BIT = 2;
  localparam int OVF_BIT = 1;
  localparam int UNF_BIT = 0;
  localparam logic [FLAG_W-1:0] UNIT_MASK = FLAG_W'((1 << INV_BIT) | (1 << IFZ_BIT));

  typedef struct packed {
    logic capture;   // load stage 0 with a fresh operation
    logic flagForm;  // stage 0 keeps the flag vector instead of the magnitude
  } dpStrobe_t;
endpackage

// File: rtl/fp_abs_dp.sv
module fp_abs_dp
  import fp_abs_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int LATENCY = 3,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcOperand,
  output logic [DATA_W-1:0] outData,
  output logic [FLAG_W-1:0] outFlags
);
  logic [EXP_W-1:0]  expField;
  logic [MAN_W-1:0]  manField;
  logic              expZero, expOnes, manZero, quietBit;
  logic [DATA_W-1:0] magnitude;
  logic [FLAG_W-1:0] rawFlags;
  logic [DATA_W-1:0] stageIn;

  logic [DATA_W-1:0] resPipe [LATENCY];
  logic [FLAG_W-1:0] flgPipe [LATENCY];

  assign expField = srcOperand[DATA_W-2 -: EXP_W];
  assign manField = srcOperand[MAN_W-1:0];
  assign expZero  = (expField == '0);
  assign expOnes  = (expField == '1);
  assign manZero  = (manField == '0);
  assign quietBit = manField[MAN_W-1];

  // classification and result selection
  always_comb begin
    rawFlags  = '0;
    magnitude = {1'b0, srcOperand[DATA_W-2:0]};
    if (expZero && !manZero) begin
      magnitude         = '0;
      rawFlags[IFZ_BIT] = 1'b1;
    end else if (expOnes && !manZero) begin
      magnitude = '1;
      if (!quietBit) rawFlags[INV_BIT] = 1'b1;
    end
  end

  assign stageIn = strobe.flagForm ? {{(DATA_W-FLAG_W){1'b0}}, rawFlags} : magnitude;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resPipe[0] <= '0;
      flgPipe[0] <= '0;
    end else if (strobe.capture) begin
      resPipe[0] <= stageIn;
      flgPipe[0] <= rawFlags;
    end
  end

  for (genvar s = 1; s < LATENCY; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resPipe[s] <= '0;
        flgPipe[s] <= '0;
      end else begin
        resPipe[s] <= resPipe[s-1];
        flgPipe[s] <= flgPipe[s-1];
      end
    end
  end

  assign outData  = resPipe[LATENCY-1];
  assign outFlags = flgPipe[LATENCY-1];

  a_r4_r5_nan_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.flagForm && expOnes && !manZero) |=> (resPipe[0] == '1));

  a_r3_subnormal_flush: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.flagForm && expZero) |=> (resPipe[0] == '0));

  a_r2_sign_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.flagForm) |=> (!resPipe[0][DATA_W-1] || resPipe[0] == '1));
endmodule

// File: rtl/fp_abs_ctrl.sv
module fp_abs_ctrl
  import fp_abs_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueGuardLsb,
  input  logic              issueFlagsOnly,
  input  logic [FLAG_W-1:0] finalFlags,
  input  logic [FLAG_W-1:0] extUpdate,
  input  logic              swWrite,
  input  logic [FLAG_W-1:0] swData,
  output dpStrobe_t         strobe,
  output logic              wbValid,
  output logic [FLAG_W-1:0] flagsQ
);
  logic [LATENCY-1:0] livePipe;
  logic [LATENCY-1:0] formPipe;
  logic               commit;
  logic [FLAG_W-1:0]  unitUpd;
  logic [FLAG_W-1:0]  flagsNext;

  assign strobe.capture  = issueValid;
  assign strobe.flagForm = issueFlagsOnly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      livePipe <= '0;
      formPipe <= '0;
    end else begin
      livePipe[0] <= issueValid & issueGuardLsb;
      formPipe[0] <= issueFlagsOnly;
      for (int i = 1; i < LATENCY; i++) begin
        livePipe[i] <= livePipe[i-1];
        formPipe[i] <= formPipe[i-1];
      end
    end
  end

  assign wbValid   = livePipe[LATENCY-1];
  assign commit    = wbValid & ~formPipe[LATENCY-1];
  assign unitUpd   = commit ? (finalFlags & UNIT_MASK) : '0;
  assign flagsNext = (swWrite ? swData : flagsQ) | unitUpd | extUpdate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsNext;
  end

  a_r9_sticky_no_clear: assert property (@(posedge clk) disable iff (!rstN)
    !swWrite |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ)));

  a_r6_quiet_without_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrite && extUpdate == '0 && !wbValid) |=> (flagsQ == $past(flagsQ)));

  a_r8_unit_bits_only: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrite && extUpdate == '0) |=> (((flagsQ ^ $past(flagsQ)) & ~UNIT_MASK) == '0));
endmodule

// File: rtl/fp_abs_unit.sv
module fp_abs_unit
  import fp_abs_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int LATENCY = 3,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueGuardLsb,
  input  logic              issueFlagsOnly,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [FLAG_W-1:0] extUpdate,
  input  logic              swWrite,
  input  logic [FLAG_W-1:0] swData,
  output logic              wbValid,
  output logic [DATA_W-1:0] wbData,
  output logic [FLAG_W-1:0] flagsOut
);
  dpStrobe_t         strobe;
  logic [FLAG_W-1:0] finalFlags;

  fp_abs_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueGuardLsb(issueGuardLsb), .issueFlagsOnly(issueFlagsOnly),
    .finalFlags(finalFlags), .extUpdate(extUpdate),
    .swWrite(swWrite), .swData(swData),
    .strobe(strobe), .wbValid(wbValid), .flagsQ(flagsOut)
  );

  fp_abs_dp #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LATENCY(LATENCY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcOperand(srcOperand),
    .outData(wbData), .outFlags(finalFlags)
  );

  a_r10_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!wbValid && flagsOut == '0) || rstN);
endmodule

// File: tb/fp_abs_unit_test.sv
`timescale 1ns/1ps
module fp_abs_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0, issueGuardLsb = 1'b0, issueFlagsOnly = 1'b0;
  logic [31:0] srcOperand = '0;
  logic [4:0]  extUpdate = '0;
  logic        swWrite = 1'b0;
  logic [4:0]  swData = '0;
  logic        wbValid;
  logic [31:0] wbData;
  logic [4:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  logic [4:0] model = '0;

  localparam logic [4:0] F_INV = 5'h10;
  localparam logic [4:0] F_IFZ = 5'h08;

  fp_abs_unit uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueGuardLsb(issueGuardLsb),
    .issueFlagsOnly(issueFlagsOnly), .srcOperand(srcOperand), .extUpdate(extUpdate),
    .swWrite(swWrite), .swData(swData), .wbValid(wbValid), .wbData(wbData), .flagsOut(flagsOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation; ext is presented on the commit edge
  task automatic runOp(input string tag, input logic [31:0] src, input logic g, input logic fo,
                       input logic [31:0] expData, input logic [4:0] unitFl, input logic [4:0] ext);
    @(negedge clk);
    issueValid = 1'b1; issueGuardLsb = g; issueFlagsOnly = fo; srcOperand = src;
    @(negedge clk);
    issueValid = 1'b0;
    @(negedge clk);
    check({tag, " early R1"}, {31'b0, wbValid}, 32'd0);
    @(negedge clk);
    check({tag, " valid"}, {31'b0, wbValid}, {31'b0, g});
    if (g) check({tag, " data"}, wbData, expData);
    extUpdate = ext;
    @(negedge clk);
    extUpdate = '0;
    if (g && !fo) model = model | unitFl;
    model = model | ext;
    check({tag, " flags"}, {27'b0, flagsOut}, {27'b0, model});
  endtask

  task automatic writeFlags(input string tag, input logic [4:0] v, input logic [4:0] ext);
    @(negedge clk);
    swWrite = 1'b1; swData = v; extUpdate = ext;
    @(negedge clk);
    swWrite = 1'b0; extUpdate = '0;
    model = v | ext;
    check(tag, {27'b0, flagsOut}, {27'b0, model});
  endtask

  task automatic testReset();
    check("R10 wbValid in reset", {31'b0, wbValid}, 32'd0);
    check("R10 flags in reset", {27'b0, flagsOut}, 32'd0);
  endtask

  task automatic testMagnitudes();
    runOp("R2 positive", 32'h40400000, 1'b1, 1'b0, 32'h40400000, 5'h0, 5'h0);
    runOp("R2 negative", 32'hbf800000, 1'b1, 1'b0, 32'h3f800000, 5'h0, 5'h0);
    runOp("R2 max neg", 32'hff7fffff, 1'b1, 1'b0, 32'h7f7fffff, 5'h0, 5'h0);
    runOp("R2 neg inf", 32'hff800000, 1'b1, 1'b0, 32'h7f800000, 5'h0, 5'h0);
    runOp("R2 neg zero", 32'h80000000, 1'b1, 1'b0, 32'h00000000, 5'h0, 5'h0);
  endtask

  task automatic testSpecials();
    runOp("R4 quiet nan", 32'hffffffff, 1'b1, 1'b0, 32'hffffffff, 5'h0, 5'h0);
    runOp("R5 signalling nan", 32'hffbfffff, 1'b1, 1'b0, 32'hffffffff, F_INV, 5'h0);
    writeFlags("R9 clear", 5'h0, 5'h0);
    runOp("R3 subnormal", 32'h00400000, 1'b1, 1'b0, 32'h00000000, F_IFZ, 5'h0);
    runOp("R3 neg subnormal", 32'h807fffff, 1'b1, 1'b0, 32'h00000000, F_IFZ, 5'h0);
  endtask

  task automatic testGuardAndMode();
    runOp("R6 guard false", 32'hffbfffff, 1'b0, 1'b0, 32'h0, F_INV, 5'h0);
    runOp("R7 flags-only snan", 32'hffbfffff, 1'b1, 1'b1, 32'h00000010, F_INV, 5'h0);
    runOp("R7 flags-only subnormal", 32'h00000001, 1'b1, 1'b1, 32'h00000008, F_IFZ, 5'h0);
    runOp("R7 flags-only guard false", 32'hffbfffff, 1'b0, 1'b1, 32'h0, F_INV, 5'h0);
  endtask

  task automatic testMerge();
    writeFlags("R9 clear before merge", 5'h0, 5'h0);
    runOp("R8 merge ext", 32'hffbfffff, 1'b1, 1'b0, 32'hffffffff, F_INV, 5'h02);
    writeFlags("R9 write with ext", 5'h04, 5'h01);
  endtask

  task automatic testBackToBack();
    writeFlags("R9 clear before burst", 5'h0, 5'h0);
    @(negedge clk);
    issueValid = 1'b1; issueGuardLsb = 1'b1; issueFlagsOnly = 1'b0; srcOperand = 32'hbf800000;
    @(negedge clk);
    srcOperand = 32'h00000005;
    @(negedge clk);
    srcOperand = 32'h7f800001;
    @(negedge clk);
    issueValid = 1'b0;
    check("R1 burst a valid", {31'b0, wbValid}, 32'd1);
    check("R1 burst a data", wbData, 32'h3f800000);
    @(negedge clk);
    check("R1 burst b data", wbData, 32'h00000000);
    @(negedge clk);
    check("R1 burst c valid", {31'b0, wbValid}, 32'd1);
    check("R1 burst c data", wbData, 32'hffffffff);
    @(negedge clk);
    check("R1 burst drained", {31'b0, wbValid}, 32'd0);
    model = F_IFZ | F_INV;
    check("R8 burst flags", {27'b0, flagsOut}, {27'b0, model});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testMagnitudes();
    testSpecials();
    testGuardAndMode();
    testMerge();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule